// File: doc/BRIEF.md
# Fixed-Latency Iterative Integer Divider

This block is a multi-cycle integer divider that sits beside a processor's execute stage, in the same way a separate multiplier unit does. The pipeline hands it two 64-bit operands and three control flags taken straight from instruction-word bits. The flags select the remainder instead of the quotient, signed instead of unsigned arithmetic, and 32-bit (word) instead of 64-bit operation. A single-cycle `start` launches the operation. The block raises `busy` while it works and pulses `done` when `result` is valid.

The operation runs as a restoring shift-subtract loop on operand magnitudes. It always takes 64 iterations, whatever the operand width. Signs are applied after the loop. In word mode the low halves of the operands are widened before the loop and the result is widened from bit 31 afterwards. A zero divisor is not treated as an error: the operation runs its usual length and yields zero.

Top module: `int_divider`

## Requirements
- R1: A `start` high at a clock edge where `busy` is low captures the operands and the flags, and `busy` is high from the next cycle.
- R2: `done` goes high exactly 64 cycles after the accepting edge, for 64-bit and word operations alike; at that edge `busy` drops.
- R3: `done` is high for exactly one cycle per accepted operation.
- R4: `start` while `busy` is high is ignored: the running operation's result and latency do not change.
- R5: With `want_rem`=0 and `is_signed`=0 the result is the unsigned quotient, truncated.
- R6: With `want_rem`=1 the result is the remainder instead of the quotient.
- R7: With `is_signed`=1 the quotient is negative (two's complement) when exactly one operand is negative, and it rounds toward zero.
- R8: With `is_signed`=1 the remainder takes the sign of the dividend.
- R9: With `is_word`=1 only bits 31:0 of each operand are used, sign-extended if `is_signed`=1 and zero-extended otherwise. The result is the low 32 bits of the answer, extended from bit 31 in the same way.
- R10: A zero divisor, after word-mode truncation, gives a result of 0 after the normal 64 cycles.
- R11: Synchronous active-high `rst` makes `busy` and `done` low on the next cycle, and abandons any running operation.
- R12: `result` holds its value from `done` until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch request, accepted only while idle |
| dividend | input | 64 | Dividend operand |
| divisor | input | 64 | Divisor operand |
| want_rem | input | 1 | 1 returns remainder, 0 returns quotient |
| is_signed | input | 1 | 1 treats operands as two's complement |
| is_word | input | 1 | 1 selects 32-bit operation |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: `result` valid |
| result | output | 64 | Quotient or remainder |

## Verification
Assertions check the handshake timing on every cycle. These cover acceptance into busy, the exact 64-cycle gap from acceptance to `done`, the single-cycle `done` pulse and the idle state after reset. They also check that captured operands stay frozen while busy, so a late `start` cannot disturb them, and that `result` does not move while idle. The arithmetic itself can only be shown by the bench's scenarios. These cover the sign combinations, remainder sign, word-mode truncation and extension with garbage in the upper operand halves, the most-negative-by-minus-one case, zero divisors, and a reset that lands mid-operation.

// File: rtl/div_pkg.sv
package div_pkg;

    localparam int DATA_W = 64;
    localparam int WORD_W = 32;
    localparam int ITERS  = DATA_W;

    // Operation request as decoded from instruction bits
    typedef struct packed {
        logic want_rem;
        logic is_signed;
        logic is_word;
    } div_op_t;

    // Control carried alongside the iteration to the result stage
    typedef struct packed {
        logic want_rem;
        logic res_sext;
        logic is_word;
        logic neg_quo;
        logic neg_rem;
        logic div_zero;
    } div_ctl_t;

    // Widen the low word of a value, by sign or by zero
    function automatic logic [DATA_W-1:0] widen_word(input logic [DATA_W-1:0] v,
                                                     input logic sext);
        logic fill;
        fill = sext & v[WORD_W-1];
        return {{(DATA_W-WORD_W){fill}}, v[WORD_W-1:0]};
    endfunction

    function automatic logic [DATA_W-1:0] cond_negate(input logic [DATA_W-1:0] v,
                                                      input logic neg);
        return neg ? (~v + 1'b1) : v;
    endfunction

endpackage

// File: rtl/div_prep.sv
module div_prep
    import div_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  div_op_t      op,
    output logic [W-1:0] a_mag,
    output logic [W-1:0] b_mag,
    output div_ctl_t     ctl
);
    logic [W-1:0] a_ext, b_ext;
    logic         a_neg, b_neg;

    always_comb begin
        a_ext = op.is_word ? widen_word(a_in, op.is_signed) : a_in;
        b_ext = op.is_word ? widen_word(b_in, op.is_signed) : b_in;
        a_neg = op.is_signed & a_ext[W-1];
        b_neg = op.is_signed & b_ext[W-1];
        a_mag = cond_negate(a_ext, a_neg);
        b_mag = cond_negate(b_ext, b_neg);

        ctl.want_rem = op.want_rem;
        ctl.res_sext = op.is_signed;
        ctl.is_word  = op.is_word;
        ctl.neg_quo  = a_neg ^ b_neg;
        ctl.neg_rem  = a_neg;
        ctl.div_zero = (b_ext == '0);
    end
endmodule

// File: rtl/div_core.sv
module div_core
    import div_pkg::*;
#(
    parameter int W = DATA_W,
    parameter int N = ITERS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] a_mag,
    input  logic [W-1:0] b_mag,
    input  div_ctl_t     ctl_in,
    output logic         busy,
    output logic         done,
    output div_ctl_t     ctl_out,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);
    localparam int CW = (N > 1) ? $clog2(N) : 1;
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    logic [CW-1:0] cnt_q;
    logic          busy_q, done_q;
    logic [W-1:0]  quo_q, rem_q, dvsr_q;
    div_ctl_t      ctl_q;

    logic [W:0]    shifted, diff;
    logic          fits;

    always_comb begin
        shifted = {rem_q, quo_q[W-1]};
        diff    = shifted - {1'b0, dvsr_q};
        fits    = ~diff[W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            cnt_q  <= '0;
            quo_q  <= '0;
            rem_q  <= '0;
            dvsr_q <= '0;
            ctl_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start) begin
                    busy_q <= 1'b1;
                    cnt_q  <= '0;
                    quo_q  <= a_mag;
                    rem_q  <= '0;
                    dvsr_q <= b_mag;
                    ctl_q  <= ctl_in;
                end
            end else begin
                rem_q <= fits ? diff[W-1:0] : shifted[W-1:0];
                quo_q <= {quo_q[W-2:0], fits};
                if (cnt_q == LAST) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign busy    = busy_q;
    assign done    = done_q;
    assign ctl_out = ctl_q;
    assign quo     = quo_q;
    assign rem     = rem_q;

    // R1: accepted start leads to busy
    a_r1_start_busy: assert property (@(posedge clk) disable iff (rst)
        (start && !busy_q) |=> busy_q);

    // R3: done is a single-cycle pulse
    a_r3_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R2: done only ends a busy period
    a_r2_done_after_busy: assert property (@(posedge clk) disable iff (rst)
        done_q |-> ($past(busy_q) && !busy_q));

    // R4: captured divisor and control frozen while busy
    a_r4_operands_frozen: assert property (@(posedge clk) disable iff (rst)
        busy_q |=> ($stable(dvsr_q) && $stable(ctl_q)));
endmodule

// File: rtl/div_fix.sv
module div_fix
    import div_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] quo,
    input  logic [W-1:0] rem,
    input  div_ctl_t     ctl,
    output logic [W-1:0] result
);
    logic [W-1:0] q_s, r_s, pick;

    always_comb begin
        q_s  = cond_negate(quo, ctl.neg_quo);
        r_s  = cond_negate(rem, ctl.neg_rem);
        pick = ctl.want_rem ? r_s : q_s;
        if (ctl.is_word)
            pick = widen_word(pick, ctl.res_sext);
        result = ctl.div_zero ? '0 : pick;
    end
endmodule

// File: rtl/int_divider.sv
module int_divider
    import div_pkg::*;
#(
    parameter int W = DATA_W,
    parameter int N = ITERS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    input  logic         want_rem,
    input  logic         is_signed,
    input  logic         is_word,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] result
);
    div_op_t      op;
    div_ctl_t     ctl_new, ctl_run;
    logic [W-1:0] a_mag, b_mag, quo, rem;

    assign op = '{want_rem: want_rem, is_signed: is_signed, is_word: is_word};

    div_prep #(.W(W)) u_prep (
        .a_in  (dividend),
        .b_in  (divisor),
        .op    (op),
        .a_mag (a_mag),
        .b_mag (b_mag),
        .ctl   (ctl_new)
    );

    div_core #(.W(W), .N(N)) u_core (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .a_mag   (a_mag),
        .b_mag   (b_mag),
        .ctl_in  (ctl_new),
        .busy    (busy),
        .done    (done),
        .ctl_out (ctl_run),
        .quo     (quo),
        .rem     (rem)
    );

    div_fix #(.W(W)) u_fix (
        .quo    (quo),
        .rem    (rem),
        .ctl    (ctl_run),
        .result (result)
    );

    // Latency monitor for R2, counted outside the core's own counter
    localparam int LW = $clog2(N + 1) + 1;
    logic [LW-1:0] lat_q;

    always_ff @(posedge clk) begin
        if (rst)
            lat_q <= '0;
        else if (start && !busy)
            lat_q <= '0;
        else if (busy)
            lat_q <= lat_q + 1'b1;
    end

    // R2: done arrives exactly N cycles after acceptance
    a_r2_fixed_latency: assert property (@(posedge clk) disable iff (rst)
        done |-> (lat_q == LW'(N)));

    // R12: idle and no new request keeps the result steady
    a_r12_result_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(result));

    // R11: reset returns to idle
    always_ff @(posedge clk) begin
        if ($past(rst))
            a_r11_reset_idle: assert (!busy && !done);
    end
endmodule

// File: tb/tb_int_divider.sv
module tb_int_divider;
    import div_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [63:0] dividend = '0, divisor = '0;
    logic        want_rem = 1'b0, is_signed = 1'b0, is_word = 1'b0;
    logic        busy, done;
    logic [63:0] result;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    always #4 clk = ~clk;

    int_divider dut (
        .clk(clk), .rst(rst), .start(start),
        .dividend(dividend), .divisor(divisor),
        .want_rem(want_rem), .is_signed(is_signed), .is_word(is_word),
        .busy(busy), .done(done), .result(result)
    );

    typedef struct packed {
        logic [63:0] a;
        logic [63:0] b;
        logic        rem;
        logic        sgn;
        logic        word;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{64'd100, 64'd7, 1'b0, 1'b0, 1'b0},                               // R5
        '{64'd100, 64'd7, 1'b1, 1'b0, 1'b0},                               // R6
        '{-64'sd100, 64'd7, 1'b0, 1'b1, 1'b0},                             // R7
        '{64'd100, -64'sd7, 1'b0, 1'b1, 1'b0},                             // R7
        '{-64'sd100, -64'sd7, 1'b0, 1'b1, 1'b0},                           // R7
        '{-64'sd100, 64'd7, 1'b1, 1'b1, 1'b0},                             // R8
        '{64'd100, -64'sd7, 1'b1, 1'b1, 1'b0},                             // R8
        '{64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 1'b0, 1'b0, 1'b0},               // R5
        '{64'h8000_0000_0000_0000, -64'sd1, 1'b0, 1'b1, 1'b0},             // R7
        '{64'hFFFF_FFFF_0000_0064, 64'h1234_0000_0000_0007, 1'b0, 1'b0, 1'b1}, // R9
        '{64'h0000_0000_FFFF_FF9C, 64'd7, 1'b0, 1'b1, 1'b1},               // R9
        '{64'h0000_0000_FFFF_FF9C, 64'd7, 1'b1, 1'b1, 1'b1},               // R9
        '{64'h0000_0000_FFFF_FFF0, 64'd1, 1'b0, 1'b0, 1'b1},               // R9
        '{64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, 1'b0, 1'b1, 1'b1}, // R9
        '{64'd12345, 64'd0, 1'b0, 1'b1, 1'b0},                             // R10
        '{64'd12345, 64'hFFFF_FFFF_0000_0000, 1'b1, 1'b0, 1'b1}            // R10
    };

    function automatic logic [63:0] ext32(input logic [63:0] v, input logic s);
        return {{32{s & v[31]}}, v[31:0]};
    endfunction

    function automatic logic [63:0] model(input vec_t v);
        logic [63:0] a, b, ma, mb, q, r, res;
        logic na, nb;
        a = v.word ? ext32(v.a, v.sgn) : v.a;
        b = v.word ? ext32(v.b, v.sgn) : v.b;
        if (b == 64'd0) return 64'd0;
        na = v.sgn & a[63];
        nb = v.sgn & b[63];
        ma = na ? -a : a;
        mb = nb ? -b : b;
        q = ma / mb;
        r = ma % mb;
        if (na ^ nb) q = -q;
        if (na) r = -r;
        res = v.rem ? r : q;
        if (v.word) res = ext32(res, v.sgn);
        return res;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!ended) begin
            ended = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    // Run one operation; optionally fire a stray start mid-run
    task automatic run_op(input vec_t v, input bit poke, input string tag);
        int lat;
        @(negedge clk);
        dividend = v.a; divisor = v.b;
        want_rem = v.rem; is_signed = v.sgn; is_word = v.word;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check({tag, " R1 busy"}, {63'd0, busy}, 64'd1);
        lat = 0;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
            if (poke && lat == 5) begin
                dividend = 64'd999; divisor = 64'd2;
                want_rem = ~v.rem; is_signed = ~v.sgn; is_word = ~v.word;
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        check({tag, " R2 latency"}, 64'(lat), 64'd64);
        check({tag, " result"}, result, model(v));
        @(negedge clk);
        check({tag, " R3 done one cycle"}, {63'd0, done}, 64'd0);
        check({tag, " R12 result held"}, result, model(v));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 busy in reset", {63'd0, busy}, 64'd0);
        check("R11 done in reset", {63'd0, done}, 64'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++)
            run_op(VECS[i], 1'b0, $sformatf("vec%0d", i));

        // R4: stray start while busy is ignored
        run_op(VECS[2], 1'b1, "R4 stray start signed");
        run_op(VECS[10], 1'b1, "R4 stray start word");

        // R11: reset mid-operation abandons the run
        @(negedge clk);
        dividend = 64'd50; divisor = 64'd5;
        want_rem = 0; is_signed = 0; is_word = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R11 busy after mid reset", {63'd0, busy}, 64'd0);
        begin
            bit saw = 0;
            repeat (70) begin
                @(negedge clk);
                if (done || busy) saw = 1;
            end
            check("R11 no completion after reset", {63'd0, saw}, 64'd0);
        end

        // Back to normal operation after reset
        run_op(VECS[0], 1'b0, "R5 after reset");
        report();
    end
endmodule